// File: doc/BRIEF.md
# Sectored Flash Program/Erase Controller

This block models the control side of a byte-wide flash device whose storage is divided into equal sectors. A host talks to it over a parallel bus made of active-low chip enable, output enable and write enable strobes, an address and a byte of data. The block decodes each bus cycle and recognises unlock command sequences. It captures the target address and data, then runs a timed program of one byte, or an erase that covers one sector, several sectors or the whole array. All of this runs against an on-chip storage array.

While an operation runs, a read returns a status byte instead of array data, and the host polls that byte to detect completion. An erase may be suspended. During the suspend the host can read, and program, sectors that are not part of the erase. A resume command then continues the erase. A per-sector protection input blocks program and erase on the sectors it marks. All pulse durations are parameters counted in clock cycles. The full device uses `SECT_BITS=3` and `SECT_AW=16` (19 address bits, 512 KB), and the default is a reduced array.

Top module: `flash_sector_ctrl`

## Requirements
- R1: The top `SECT_BITS` address bits select the sector, so sector n covers addresses n*2^SECT_AW through n*2^SECT_AW + 2^SECT_AW - 1. Program and erase act only inside the sectors they select.
- R2: `dout_en` is high only during a read cycle (`ce_n`=0, `oe_n`=0, `we_n`=1). With `ce_n` high, or with `oe_n` high, the output is disabled. A command write is sampled on the first clock of a cycle with `ce_n`=0, `we_n`=0 and `oe_n`=1.
- R3: After reset the block is in array-read mode. A read returns the stored byte with no command issued, and an unwritten array reads 0xFF.
- R4: Programming takes four writes: 0xAA at an address whose low bits are 0x55, 0x55 at low bits 0xAA, 0xA0 at low bits 0x55, then the data at the target address. When it finishes, the block is back in array-read mode. The low-bits compare uses min(8, SECT_AW) bits.
- R5: An erase starts with two unlock pairs around 0x80. It then takes either 0x10 at low bits 0x55 for the whole array, or 0x30 at a sector address. Each further 0x30 write within `WIN_CYC` cycles adds that sector. The erase preprograms the selected bytes to 0x00, waits `ERASE_CYC`, writes 0xFF and verifies. It leaves every other sector unchanged.
- R6: A sector whose `prot` bit is set, with the bit held steady during the operation, is never written. A program aimed at it is dropped at once, and an erase skips it.
- R7: While a program runs, a read returns bit 7 as the complement of bit 7 of the data being written, and bit 6 inverts on each successive read.
- R8: While an erase runs, a read returns bit 7 = 0, and bit 6 inverts on each read. Bit 2 inverts on a read only when the addressed sector is selected for the erase, during both the erase and its suspend.
- R9: Writing 0xB0 during an erase suspends it. While suspended, a sector outside the erase reads array data and accepts a program. A sector in the erase reads a status byte with bit 7 = 1 and a steady bit 6, and a program aimed at it is dropped. Writing 0x30 resumes the erase from where it stopped.
- R10: An operation runs to completion even while the chip is deselected. The block then accepts a new command.
- R11: A program stores the old byte AND the written data, so it can only clear bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | SECT_BITS+SECT_AW | Byte address |
| din | input | 8 | Write data / command byte |
| prot | input | 2**SECT_BITS | Per-sector protection flags |
| dout | output | 8 | Read data or status, 0 when not reading |
| dout_en | output | 1 | Output drive enable |

## Verification
The bench checks that a multi-sector erase clears the last byte of a chosen sector but leaves the first byte of the next sector alone. A sector decode that was off by one would corrupt that neighbour. It reads pairs of status bytes and compares bit 6 and bit 2 between them. This exposes a toggle that never moves, or a second toggle bit that also moves for sectors outside the erase. During a suspend it reads and programs an unrelated sector, then resumes and confirms that the erase still completes. A design that lost its erase progress, or allowed a write into the erasing sector, would leave wrong contents behind. Protected sectors must keep their data through a sector erase and a whole-array erase, and a program that clears bits must read back the AND of the old and new values.

// File: rtl/flash_sector_ctrl.sv
module flash_sector_ctrl #(
  parameter int SECT_BITS = 3,
  parameter int SECT_AW   = 8,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 64,
  parameter int WIN_CYC   = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ce_n,
  input  logic                         oe_n,
  input  logic                         we_n,
  input  logic [SECT_BITS+SECT_AW-1:0] addr,
  input  logic [7:0]                   din,
  input  logic [(1<<SECT_BITS)-1:0]    prot,
  output logic [7:0]                   dout,
  output logic                         dout_en
);
  localparam int NSECT = 1 << SECT_BITS;
  localparam int AW    = SECT_BITS + SECT_AW;
  localparam int DEPTH = 1 << AW;
  localparam int ULW   = (SECT_AW < 8) ? SECT_AW : 8;
  localparam int PCW   = $clog2(PROG_CYC + 1);
  localparam int ECW   = $clog2(ERASE_CYC + WIN_CYC + 1);
  localparam logic [7:0] UL1 = 8'h55;
  localparam logic [7:0] UL2 = 8'hAA;

  typedef enum logic [3:0] {
    S_READ, S_U1, S_U2, S_PARM, S_PRUN, S_E0, S_E1, S_E2,
    S_WIN, S_PRE, S_PULSE, S_WR, S_VER, S_SUSP
  } st_t;

  st_t st, rphase;
  logic [7:0] mem [DEPTH];
  logic wr_q, rd_q, susp, tog6, tog2;
  logic [AW-1:0] raddr, paddr, ptr, mem_wa;
  logic [7:0] pdata, mem_wd;
  logic [NSECT-1:0] sel;
  logic [PCW-1:0] pcnt;
  logic [ECW-1:0] ecnt;
  logic mem_we;

  initial for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;

  wire rd  = !ce_n && !oe_n && we_n;
  wire wr  = !ce_n && !we_n && oe_n;
  wire ws  = wr && !wr_q;
  wire rd_end = rd_q && !rd;
  wire is_u1 = addr[ULW-1:0] == UL1[ULW-1:0];
  wire is_u2 = addr[ULW-1:0] == UL2[ULW-1:0];
  wire [SECT_BITS-1:0] asec = addr[AW-1:SECT_AW];
  wire [SECT_BITS-1:0] rsec = raddr[AW-1:SECT_AW];
  wire [SECT_BITS-1:0] psec = ptr[AW-1:SECT_AW];
  wire [SECT_BITS-1:0] wsec = mem_wa[AW-1:SECT_AW];
  wire [NSECT-1:0] aone = NSECT'(1) << asec;
  wire [7:0] cur  = mem[addr];
  wire [7:0] pv   = mem[ptr];
  wire [7:0] pold = mem[paddr];
  wire ptr_sel  = sel[psec];
  wire ptr_last = &ptr;
  wire prog_wr  = st == S_PRUN;
  wire er_active = st inside {S_WIN, S_PRE, S_PULSE, S_WR, S_VER};
  wire er_run   = susp || (st inside {S_PRE, S_PULSE, S_WR, S_VER});
  wire susp_cmd = ws && din == 8'hB0;
  wire p_done   = pcnt == PCW'(PROG_CYC - 1);
  st_t home;
  assign home = susp ? S_SUSP : S_READ;

  always_comb begin
    mem_we = 1'b0;
    mem_wa = ptr;
    mem_wd = 8'hFF;
    case (st)
      S_PRUN:  if (p_done) begin mem_we = 1'b1; mem_wa = paddr; mem_wd = pold & pdata; end
      S_PRE:   if (ptr_sel && pv != 8'h00) begin mem_we = 1'b1; mem_wd = 8'h00; end
      S_WR:    if (ptr_sel) mem_we = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) if (mem_we) mem[mem_wa] <= mem_wd;

  wire [7:0] stat = {1'b0, tog6, 3'b000, tog2, 2'b00};
  assign dout_en = rd;
  assign dout = !rd ? 8'h00 :
                prog_wr ? (stat | {~pdata[7], 7'd0}) :
                er_active ? stat :
                (susp && sel[asec]) ? (stat | 8'h80) : cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_READ; rphase <= S_READ;
      wr_q <= 1'b0; rd_q <= 1'b0; susp <= 1'b0;
      tog6 <= 1'b0; tog2 <= 1'b0;
      raddr <= '0; paddr <= '0; pdata <= '0; ptr <= '0;
      sel <= '0; pcnt <= '0; ecnt <= '0;
    end else begin
      wr_q <= wr;
      rd_q <= rd;
      if (rd) raddr <= addr;
      if (rd_end && (prog_wr || er_active)) tog6 <= ~tog6;
      if (rd_end && (er_active || susp) && sel[rsec]) tog2 <= ~tog2;
      case (st)
        S_READ: if (ws && din == 8'hAA && is_u1) st <= S_U1;
        S_SUSP: if (ws) begin
          if (din == 8'h30) begin st <= rphase; susp <= 1'b0; end
          else if (din == 8'hAA && is_u1) st <= S_U1;
        end
        S_U1: if (ws) st <= (din == 8'h55 && is_u2) ? S_U2 : home;
        S_U2: if (ws) begin
          if (din == 8'hA0 && is_u1) st <= S_PARM;
          else if (din == 8'h80 && is_u1 && !susp) st <= S_E0;
          else st <= home;
        end
        S_PARM: if (ws) begin
          if (prot[asec] || (susp && sel[asec])) st <= home;
          else begin paddr <= addr; pdata <= din; pcnt <= '0; st <= S_PRUN; end
        end
        S_PRUN: if (p_done) st <= home; else pcnt <= pcnt + 1'b1;
        S_E0: if (ws) st <= (din == 8'hAA && is_u1) ? S_E1 : S_READ;
        S_E1: if (ws) st <= (din == 8'h55 && is_u2) ? S_E2 : S_READ;
        S_E2: if (ws) begin
          if (din == 8'h10 && is_u1) begin
            sel <= ~prot; ptr <= '0;
            st <= (&prot) ? S_READ : S_PRE;
          end else if (din == 8'h30) begin
            sel <= aone & ~prot; ecnt <= '0; st <= S_WIN;
          end else st <= S_READ;
        end
        S_WIN: begin
          if (ws && din == 8'h30) begin sel <= sel | (aone & ~prot); ecnt <= '0; end
          else if (ws) begin sel <= '0; st <= S_READ; end
          else if (ecnt == ECW'(WIN_CYC - 1)) begin
            if (sel == '0) st <= S_READ;
            else begin ptr <= '0; st <= S_PRE; end
          end else ecnt <= ecnt + 1'b1;
        end
        S_PRE, S_PULSE, S_WR, S_VER: begin
          if (susp_cmd) begin rphase <= st; st <= S_SUSP; susp <= 1'b1; end
          else if (st == S_PULSE) begin
            if (ecnt == ECW'(ERASE_CYC - 1)) begin ptr <= '0; st <= S_WR; end
            else ecnt <= ecnt + 1'b1;
          end else if (st == S_VER && ptr_sel && pv != 8'hFF) begin
            ptr <= '0; ecnt <= '0; st <= S_PULSE;
          end else begin
            ptr <= ptr + 1'b1;
            if (ptr_last) begin
              case (st)
                S_PRE:   begin st <= S_PULSE; ecnt <= '0; end
                S_WR:    st <= S_VER;
                default: begin st <= S_READ; sel <= '0; end
              endcase
            end
          end
        end
        default: st <= S_READ;
      endcase
    end
  end
endmodule

// File: rtl/flash_sector_ctrl_chk.sv
module flash_sector_ctrl_chk #(
  parameter int NSECT     = 8,
  parameter int SECT_BITS = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ce_n,
  input logic                 oe_n,
  input logic                 dout_en,
  input logic                 mem_we,
  input logic [SECT_BITS-1:0] wsec,
  input logic [NSECT-1:0]     prot,
  input logic [NSECT-1:0]     sel,
  input logic                 susp,
  input logic                 prog_wr,
  input logic                 er_run,
  input logic [7:0]           mem_wd,
  input logic [7:0]           mem_old
);
  AST_STANDBY_HIZ: assert property (@(posedge clk) disable iff (!rst_n) (ce_n || oe_n) |-> !dout_en); // R2
  AST_PROT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> !prot[wsec]); // R6
  AST_SUSP_SEL_SAFE: assert property (@(posedge clk) disable iff (!rst_n) (mem_we && susp) |-> !sel[wsec]); // R9
  AST_PROG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (mem_we && prog_wr) |-> ((mem_wd & ~mem_old) == 8'h00)); // R11
  AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n) (er_run && $past(er_run)) |-> $stable(sel)); // R5
endmodule

bind flash_sector_ctrl flash_sector_ctrl_chk #(.NSECT(NSECT), .SECT_BITS(SECT_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .dout_en(dout_en),
  .mem_we(mem_we), .wsec(wsec), .prot(prot), .sel(sel), .susp(susp),
  .prog_wr(prog_wr), .er_run(er_run), .mem_wd(mem_wd), .mem_old(pold)
);

// File: tb/flash_sector_ctrl_bench.sv
module flash_sector_ctrl_bench;
  localparam int SB = 3, SAW = 4, AW = SB + SAW;
  localparam logic [AW-1:0] UA = 7'h55, UB = 7'h2A;

  logic clk = 1'b0, rst_n = 1'b0, ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0, dout;
  logic [7:0] prot = '0;
  logic dout_en;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  flash_sector_ctrl #(.SECT_BITS(SB), .SECT_AW(SAW), .PROG_CYC(40), .ERASE_CYC(300), .WIN_CYC(30)) u_flash_sector_ctrl (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .prot(prot), .dout(dout), .dout_en(dout_en));

  typedef struct { logic [7:0] exp; logic [7:0] mask; string tag; } item_t;
  item_t q[$];
  logic [7:0] obs;
  event got;

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s act=%02h exp=%02h", tag, act, exp); end
  endtask

  initial forever begin
    @(got);
    begin
      item_t it = q.pop_front();
      check((obs & it.mask) == (it.exp & it.mask), it.tag, obs & it.mask, it.exp & it.mask);
    end
  end

  task automatic bus_wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; din = d; ce_n = 0; oe_n = 1; we_n = 0;
    @(negedge clk); we_n = 1; ce_n = 1;
    @(negedge clk);
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; ce_n = 0; oe_n = 0; we_n = 1;
    @(negedge clk); d = dout; oe_n = 1; ce_n = 1;
    @(negedge clk);
  endtask

  task automatic expect_rd(input logic [AW-1:0] a, input logic [7:0] e, input logic [7:0] m, input string tag);
    logic [7:0] v;
    q.push_back('{e, m, tag});
    bus_rd(a, v);
    obs = v;
    ->got;
    #1;
  endtask

  task automatic prog(input logic [AW-1:0] a, input logic [7:0] d);
    bus_wr(UA, 8'hAA); bus_wr(UB, 8'h55); bus_wr(UA, 8'hA0); bus_wr(a, d);
  endtask

  task automatic er_setup();
    bus_wr(UA, 8'hAA); bus_wr(UB, 8'h55); bus_wr(UA, 8'h80);
    bus_wr(UA, 8'hAA); bus_wr(UB, 8'h55);
  endtask

  task automatic wait_ready(input logic [AW-1:0] a);
    logic [7:0] x, y;
    bit done = 0;
    for (int i = 0; i < 3000 && !done; i++) begin
      bus_rd(a, x); bus_rd(a, y);
      if (x[6] == y[6]) done = 1;
    end
    if (!done) check(0, "ready", x, y);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=00 exp=01");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] x, y;
    repeat (4) @(negedge clk);
    check(dout_en == 1'b0, "R2 reset", {7'd0, dout_en}, 8'h00);
    rst_n = 1'b1;
    expect_rd(7'h00, 8'hFF, 8'hFF, "R3 array read after reset");
    expect_rd(7'h7F, 8'hFF, 8'hFF, "R3 top byte");

    prog(7'h05, 8'hA5);
    bus_rd(7'h05, x); bus_rd(7'h05, y);
    check(x[7] == 1'b0, "R7 bit7 complement", x, 8'h00);
    check(x[6] != y[6], "R7 bit6 toggle", y, ~x);
    wait_ready(7'h05);
    expect_rd(7'h05, 8'hA5, 8'hFF, "R4 program");

    prog(7'h05, 8'h3C);
    bus_rd(7'h05, x);
    check(x[7] == 1'b1, "R7 bit7 complement", x, 8'h80);
    wait_ready(7'h05);
    expect_rd(7'h05, 8'h24, 8'hFF, "R11 and program");

    prog(7'h10, 8'h0F);
    @(negedge clk); ce_n = 1; oe_n = 0;
    @(negedge clk);
    check(dout_en == 1'b0, "R2 ce high", {7'd0, dout_en}, 8'h00);
    ce_n = 0; oe_n = 1;
    @(negedge clk);
    check(dout_en == 1'b0, "R2 oe high", {7'd0, dout_en}, 8'h00);
    ce_n = 1;
    repeat (60) @(negedge clk);
    expect_rd(7'h10, 8'h0F, 8'hFF, "R10 deselected completion");
    prog(7'h11, 8'h77);
    wait_ready(7'h11);
    expect_rd(7'h11, 8'h77, 8'hFF, "R10 next command");

    prog(7'h20, 8'h00); wait_ready(7'h20);
    prog(7'h3F, 8'h12); wait_ready(7'h3F);
    prog(7'h30, 8'h34); wait_ready(7'h30);
    prog(7'h40, 8'h56); wait_ready(7'h40);
    prot = 8'h04;
    prog(7'h21, 8'h00);
    expect_rd(7'h21, 8'hFF, 8'hFF, "R6 protected program dropped");

    er_setup();
    bus_wr(7'h20, 8'h30);
    bus_wr(7'h30, 8'h30);
    bus_rd(7'h30, x); bus_rd(7'h30, y);
    check(x[7] == 1'b0, "R8 erase bit7", x, 8'h00);
    check(x[6] != y[6], "R8 erase bit6", y, ~x);
    check(x[2] != y[2], "R8 bit2 selected", y, ~x);
    bus_rd(7'h40, x); bus_rd(7'h40, y);
    check(x[2] == y[2], "R8 bit2 unselected", y, x);
    wait_ready(7'h40);
    expect_rd(7'h30, 8'hFF, 8'hFF, "R5 multi erase");
    expect_rd(7'h3F, 8'hFF, 8'hFF, "R1 sector end");
    expect_rd(7'h40, 8'h56, 8'hFF, "R1 next sector kept");
    expect_rd(7'h20, 8'h00, 8'hFF, "R6 protected sector kept");
    expect_rd(7'h05, 8'h24, 8'hFF, "R5 other sector kept");

    prot = 8'h00;
    prog(7'h18, 8'h00); wait_ready(7'h18);
    er_setup();
    bus_wr(7'h18, 8'h30);
    repeat (250) @(negedge clk);
    bus_wr(7'h00, 8'hB0);
    expect_rd(7'h05, 8'h24, 8'hFF, "R9 read outside erase");
    bus_rd(7'h18, x); bus_rd(7'h18, y);
    check(x[7] == 1'b1, "R9 suspended status", x, 8'h80);
    check(x[6] == y[6], "R9 bit6 steady", y, x);
    check(x[2] != y[2], "R8 bit2 in suspend", y, ~x);
    prog(7'h06, 8'h42);
    wait_ready(7'h06);
    expect_rd(7'h06, 8'h42, 8'hFF, "R9 program in suspend");
    prog(7'h19, 8'h00);
    bus_wr(7'h00, 8'h30);
    bus_rd(7'h00, x);
    check(x[7] == 1'b0, "R9 resumed busy", x, 8'h00);
    wait_ready(7'h00);
    expect_rd(7'h18, 8'hFF, 8'hFF, "R9 erase finished");
    expect_rd(7'h19, 8'hFF, 8'hFF, "R9 program to erasing sector dropped");
    expect_rd(7'h06, 8'h42, 8'hFF, "R9 suspend program kept");

    prot = 8'h04;
    er_setup();
    bus_wr(UA, 8'h10);
    wait_ready(7'h00);
    expect_rd(7'h05, 8'hFF, 8'hFF, "R5 chip erase");
    expect_rd(7'h7F, 8'hFF, 8'hFF, "R5 chip erase top");
    expect_rd(7'h20, 8'h00, 8'hFF, "R6 chip erase skips protected");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule